// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is a purely combinational integer ALU for a 32-bit datapath. It takes two operands and a 4-bit operation code. It returns a result word, a carry flag, a signed-overflow flag and a zero flag in the same cycle. The operations are signed and unsigned addition and subtraction, four bitwise functions, and signed and unsigned less-than comparison.

Any immediate operand is sign- or zero-extended before it reaches the block. A single adder serves addition, subtraction and both comparisons. For subtraction and comparison, the second operand is inverted and the adder's carry input is forced to one. Signed overflow is taken from the carries entering and leaving the top bit.

Top module: `int_alu`

## Requirements
- R1: Codes 0 (signed add) and 1 (unsigned add) give result = opA + opB modulo 2^WIDTH, with carryOut equal to the carry leaving the top bit of that sum.
- R2: Codes 2 (signed subtract) and 3 (unsigned subtract) give result = opA - opB modulo 2^WIDTH, computed as opA + ~opB + 1, with carryOut equal to the carry leaving the top bit of that sum (1 when opA >= opB unsigned).
- R3: overflow is 1 only for codes 0 and 2, and only when the true signed sum or difference lies outside the two's-complement range of WIDTH bits. Every other code gives overflow 0.
- R4: Codes 4, 5, 6 and 7 give opA AND opB, opA OR opB, opA XOR opB and NOR(opA, opB) respectively, with carryOut and overflow both 0.
- R5: Code 10 gives result 1 when opA < opB as signed two's-complement values and 0 otherwise. Bits WIDTH-1..1 are always 0, and carryOut and overflow are 0.
- R6: Code 11 gives result 1 when opA < opB as unsigned values and 0 otherwise. Bits WIDTH-1..1 are always 0, and carryOut and overflow are 0.
- R7: zero is 1 exactly when every bit of result is 0, for every code.
- R8: Codes 8, 9, 12, 13, 14 and 15 give result 0, carryOut 0 and overflow 0 (so zero is 1).
- R9: The block has no clock or state: all outputs follow a change of the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH (32) | First operand |
| opB | input | WIDTH (32) | Second operand |
| mode | input | 4 | Operation code |
| result | output | WIDTH (32) | Operation result |
| carryOut | output | 1 | Adder carry from the top bit on add/subtract codes, else 0 |
| overflow | output | 1 | Signed overflow on codes 0 and 2 |
| zero | output | 1 | Result is all zeros |

## Verification
Every output is due in the same cycle as its stimulus, with zero register stages between the inputs and the outputs. The bench drives the operands and the code on the falling clock edge. It samples all four outputs one nanosecond later, well before the next rising edge, so each check sees the settled value for exactly one stimulus. For R9, the bench also changes the inputs halfway between edges and samples again before any edge occurs. A 4-bit instance is swept over every operand pair and every code. The 32-bit instance gets directed sign-boundary, carry-chain and comparison cases.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd10,
    OP_SLTU = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] {
    RES_SUM   = 2'd0,
    RES_LOGIC = 2'd1,
    RES_LESS  = 2'd2,
    RES_NONE  = 2'd3
  } resSel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2,
    LOG_NOR = 2'd3
  } logicOp_e;

  typedef struct packed {
    logic     invertB;
    logic     carryIn;
    logic     ovfEnable;
    logic     carryEnable;
    logic     lessUnsigned;
    resSel_e  resSel;
    logicOp_e logicOp;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output aluStrobes_t       strobes
);

  always_comb begin
    strobes              = '0;
    strobes.resSel       = RES_NONE;
    strobes.logicOp      = LOG_AND;
    case (mode)
      OP_ADD: begin
        strobes.resSel      = RES_SUM;
        strobes.ovfEnable   = 1'b1;
        strobes.carryEnable = 1'b1;
      end
      OP_ADDU: begin
        strobes.resSel      = RES_SUM;
        strobes.carryEnable = 1'b1;
      end
      OP_SUB: begin
        strobes.resSel      = RES_SUM;
        strobes.invertB     = 1'b1;
        strobes.carryIn     = 1'b1;
        strobes.ovfEnable   = 1'b1;
        strobes.carryEnable = 1'b1;
      end
      OP_SUBU: begin
        strobes.resSel      = RES_SUM;
        strobes.invertB     = 1'b1;
        strobes.carryIn     = 1'b1;
        strobes.carryEnable = 1'b1;
      end
      OP_AND: begin
        strobes.resSel  = RES_LOGIC;
        strobes.logicOp = LOG_AND;
      end
      OP_OR: begin
        strobes.resSel  = RES_LOGIC;
        strobes.logicOp = LOG_OR;
      end
      OP_XOR: begin
        strobes.resSel  = RES_LOGIC;
        strobes.logicOp = LOG_XOR;
      end
      OP_NOR: begin
        strobes.resSel  = RES_LOGIC;
        strobes.logicOp = LOG_NOR;
      end
      OP_SLT: begin
        strobes.resSel  = RES_LESS;
        strobes.invertB = 1'b1;
        strobes.carryIn = 1'b1;
      end
      OP_SLTU: begin
        strobes.resSel       = RES_LESS;
        strobes.invertB      = 1'b1;
        strobes.carryIn      = 1'b1;
        strobes.lessUnsigned = 1'b1;
      end
      default: begin
        strobes.resSel = RES_NONE;
      end
    endcase
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryIntoMsb,
  output logic             carryOutMsb
);

  logic [WIDTH:0] carryChain;

  assign carryChain[0] = carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic genBit;
    logic propBit;
    assign genBit          = addA[i] & addB[i];
    assign propBit         = addA[i] ^ addB[i];
    assign sum[i]          = propBit ^ carryChain[i];
    assign carryChain[i+1] = genBit | (propBit & carryChain[i]);
  end

  assign carryIntoMsb = carryChain[WIDTH-1];
  assign carryOutMsb  = carryChain[WIDTH];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero
);

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sum;
  logic             cIntoMsb;
  logic             cOutMsb;
  logic             rawOvf;
  logic             lessBit;
  logic [WIDTH-1:0] logicRes;

  assign bEff = opB ^ {WIDTH{strobes.invertB}};

  alu_adder #(.WIDTH(WIDTH)) adder_i (
    .addA         (opA),
    .addB         (bEff),
    .carryIn      (strobes.carryIn),
    .sum          (sum),
    .carryIntoMsb (cIntoMsb),
    .carryOutMsb  (cOutMsb)
  );

  assign rawOvf  = cIntoMsb ^ cOutMsb;
  assign lessBit = strobes.lessUnsigned ? ~cOutMsb : (sum[WIDTH-1] ^ rawOvf);

  always_comb begin
    case (strobes.logicOp)
      LOG_AND: logicRes = opA & opB;
      LOG_OR:  logicRes = opA | opB;
      LOG_XOR: logicRes = opA ^ opB;
      default: logicRes = ~(opA | opB);
    endcase
  end

  always_comb begin
    case (strobes.resSel)
      RES_SUM:   result = sum;
      RES_LOGIC: result = logicRes;
      RES_LESS:  result = {{(WIDTH-1){1'b0}}, lessBit};
      default:   result = '0;
    endcase
  end

  assign carryOut = strobes.carryEnable & cOutMsb;
  assign overflow = strobes.ovfEnable & rawOvf;
  assign zero     = ~|result;

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [MODE_W-1:0] mode,
  output logic [WIDTH-1:0]  result,
  output logic              carryOut,
  output logic              overflow,
  output logic              zero
);

  aluStrobes_t strobes;

  alu_ctrl ctrl_i (
    .mode    (mode),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow),
    .zero     (zero)
  );

endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       mode,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             overflow,
  input logic             zero
);

  logic [WIDTH-1:0] refSum;
  logic [WIDTH-1:0] refDiff;
  logic             isUnused;

  assign refSum   = opA + opB;
  assign refDiff  = opA - opB;
  assign isUnused = (mode == 4'd8) || (mode == 4'd9) || (mode >= 4'd12);

  always_comb begin
    if (mode == 4'd0 || mode == 4'd1)
      a_r1_add_sum: assert (result == refSum);
    if (mode == 4'd2 || mode == 4'd3)
      a_r2_sub_diff: assert (result == refDiff);
    if (mode != 4'd0 && mode != 4'd2)
      a_r3_no_overflow: assert (!overflow);
    if (mode >= 4'd4 && mode <= 4'd7)
      a_r4_logic_no_carry: assert (!carryOut);
    if (mode == 4'd10 || mode == 4'd11)
      a_r5_less_upper_clear: assert (result[WIDTH-1:1] == '0 && !carryOut);
    if (zero)
      a_r7_zero_means_empty: assert (result == '0);
    if (isUnused)
      a_r8_unused_quiet: assert (result == '0 && !carryOut && !overflow && zero);
  end

endmodule

bind int_alu int_alu_checker #(.WIDTH(WIDTH)) chk_i (
  .opA      (opA),
  .opB      (opB),
  .mode     (mode),
  .result   (result),
  .carryOut (carryOut),
  .overflow (overflow),
  .zero     (zero)
);

// File: tb/int_alu_tb_top.sv
`timescale 1ns/1ps
module int_alu_tb_top;

  localparam int BIG_W   = 32;
  localparam int SMALL_W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [BIG_W-1:0]   aBig, bBig, resBig;
  logic [3:0]         modeBig;
  logic               cBig, vBig, zBig;
  logic [SMALL_W-1:0] aSm, bSm, resSm;
  logic [3:0]         modeSm;
  logic               cSm, vSm, zSm;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int_alu #(.WIDTH(BIG_W)) dut_i (
    .opA(aBig), .opB(bBig), .mode(modeBig),
    .result(resBig), .carryOut(cBig), .overflow(vBig), .zero(zBig)
  );

  int_alu #(.WIDTH(SMALL_W)) dutSmall_i (
    .opA(aSm), .opB(bSm), .mode(modeSm),
    .result(resSm), .carryOut(cSm), .overflow(vSm), .zero(zSm)
  );

  task automatic check(string tag, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Independent arithmetic model of the requirements
  task automatic model(input int w, input longint unsigned a, input longint unsigned b,
                       input int m, output longint unsigned r, output bit c, output bit v,
                       output string tag);
    longint unsigned mask, full;
    longint sa, sb, sres, smax, smin;
    mask = (64'd1 << w) - 1;
    a = a & mask;
    b = b & mask;
    sa = ((a >> (w-1)) & 1) != 0 ? longint'(a) - longint'(64'd1 << w) : longint'(a);
    sb = ((b >> (w-1)) & 1) != 0 ? longint'(b) - longint'(64'd1 << w) : longint'(b);
    smax = longint'((64'd1 << (w-1)) - 1);
    smin = -smax - 1;
    r = 0; c = 0; v = 0;
    case (m)
      0, 1: begin
        tag  = "R1";
        full = a + b;
        r = full & mask;
        c = ((full >> w) & 1) != 0;
        sres = sa + sb;
        if (m == 0) v = (sres > smax) || (sres < smin);
      end
      2, 3: begin
        tag  = "R2";
        full = a + ((~b) & mask) + 1;
        r = full & mask;
        c = ((full >> w) & 1) != 0;
        sres = sa - sb;
        if (m == 2) v = (sres > smax) || (sres < smin);
      end
      4: begin tag = "R4"; r = a & b; end
      5: begin tag = "R4"; r = a | b; end
      6: begin tag = "R4"; r = a ^ b; end
      7: begin tag = "R4"; r = (~(a | b)) & mask; end
      10: begin tag = "R5"; r = (sa < sb) ? 1 : 0; end
      11: begin tag = "R6"; r = (a < b) ? 1 : 0; end
      default: begin tag = "R8"; end
    endcase
  endtask

  task automatic runBig(longint unsigned a, longint unsigned b, int m);
    longint unsigned r;
    bit c, v;
    string tag;
    @(negedge clk);
    aBig = a[BIG_W-1:0];
    bBig = b[BIG_W-1:0];
    modeBig = m[3:0];
    #1;
    model(BIG_W, a, b, m, r, c, v, tag);
    check(tag, "result32", resBig, r);
    check(tag, "carry32", cBig, c);
    check("R3", "overflow32", vBig, v);
    check("R7", "zero32", zBig, (r == 0));
  endtask

  task automatic runSmall(int a, int b, int m);
    longint unsigned r;
    bit c, v;
    string tag;
    @(negedge clk);
    aSm = a[SMALL_W-1:0];
    bSm = b[SMALL_W-1:0];
    modeSm = m[3:0];
    #1;
    model(SMALL_W, longint'(a), longint'(b), m, r, c, v, tag);
    check(tag, "result4", resSm, r);
    check(tag, "carry4", cSm, c);
    check("R3", "overflow4", vSm, v);
    check("R7", "zero4", zSm, (r == 0));
  endtask

  initial begin
    aBig = '0; bBig = '0; modeBig = '0;
    aSm = '0;  bSm = '0;  modeSm = '0;
    repeat (2) @(posedge clk);

    // Initial state: add of zeros gives zero result, flag set (R1, R7)
    @(negedge clk); #1;
    check("R1", "initial result", resBig, 0);
    check("R7", "initial zero", zBig, 1);

    // Exhaustive 4-bit sweep over all codes and operand pairs (R1..R8)
    for (int m = 0; m < 16; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          runSmall(a, b, m);

    // Directed 32-bit boundaries
    for (int m = 0; m < 16; m++) begin
      runBig(64'h7FFF_FFFF, 64'h0000_0001, m);   // R3 positive overflow on add
      runBig(64'h8000_0000, 64'h0000_0001, m);   // R3 negative overflow on sub, R5 slt
      runBig(64'hFFFF_FFFF, 64'h0000_0001, m);   // R1 carry chain full ripple, R6 sltu
      runBig(64'h8000_0000, 64'h8000_0000, m);   // R1 carry, R3 add overflow, R7 zero on sub
      runBig(64'h1234_5678, 64'h1234_5678, m);   // R2 equal operands, R7 zero
      runBig(64'h0000_0000, 64'hFFFF_FFFF, m);   // R2 borrow, R5 0 vs -1, R6
      runBig(64'hDEAD_BEEF, 64'h0F0F_F0F0, m);   // R4 mixed patterns
      runBig(64'h0000_0001, 64'h8000_0000, m);   // R5 positive vs most negative
    end

    // R9: inputs changed between edges, outputs follow with no clock edge
    @(posedge clk);
    #0.5;
    aBig = 32'd5; bBig = 32'd7; modeBig = 4'd0;
    #0.5;
    check("R9", "result without edge", resBig, 12);
    modeBig = 4'd11;
    #0.5;
    check("R9", "sltu without edge", resBig, 1);

    finished = 1;
  end

  initial begin
    int cycles = 0;
    while (!finished && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule